// File: doc/BRIEF.md
# Two-Field Memory Extension Controller

This block keeps track of which 4K field of memory a 12-bit processor fetches its instructions from and which field it uses for indirect operand accesses. It holds a one-bit instruction field, a one-bit pending-instruction-field buffer, a one-bit data field and a two-bit save register. It decodes the field-control I/O transfer words that the processor presents with an I/O strobe. On the read words it returns field values onto the accumulator input path.

A program changes its instruction field in two steps. The change-instruction word writes the buffer. The next jump or subroutine call then moves the buffer into the live field. Interrupts are held off in the time between, so that a handler can never be entered with a half-finished field change. On interrupt entry both live fields are saved and then zeroed, so the handler starts in field 0. A restore word later puts the saved values back, and the handler's closing indirect jump completes the return. The operator load-address key sets all fields at once from two panel switches.

Bit numbers in this brief count from the most significant end: bit 0 is the MSB of the 12-bit word and bit 11 is the LSB. Instruction words are given in octal.

Top module: `mem_field_ctl`

## Requirements
- R1: With `iot_strobe` high, a word matching octal 62N1 under the mask 7707 loads the data field from instruction bit 8 at the clock edge.
- R2: A word matching 62N2 under the mask 7707 loads only the buffer from instruction bit 8. The instruction field changes only on `load_addr`, `int_entry`, `clear` or reset, or on a `jmp_exec` cycle, where it takes the buffer value held before that edge.
- R3: `int_inhibit` is high in the cycle the 62N2 word is strobed. It stays high through the following `jmp_exec` cycle and is low after that edge.
- R4: On `int_entry`, save bit 0 takes the instruction field and save bit 1 takes the data field. The instruction field, the buffer and the data field are then all cleared.
- R5: Word 6244 loads the buffer from save bit 0 and the data field from save bit 1. The instruction field changes only at the next `jmp_exec`.
- R6: Words 6214 and 6224 drive the data field and the instruction field respectively onto `ac_out` bit 8 and force bits 6 and 7 to 0. All other bits pass `ac_in` through.
- R7: Word 6234 drives save bit 0 onto `ac_out` bit 8 and save bit 1 onto bit 11. All other bits pass `ac_in` through.
- R8: `ac_load` and `ac_enable` are high only in a strobed cycle carrying one of the three read words. In every other cycle they are low and `ac_out` equals `ac_in`.
- R9: `load_addr` loads both the instruction field and the buffer from `sw_ifield`, loads the data field from `sw_dfield`, and drops `int_inhibit` after the edge.
- R10: Asynchronous reset or a synchronous `clear` zeroes every field register and the inhibit.
- R11: A strobed word whose top six bits are not 62, or whose low digits match none of the six field words, changes no state and drives no accumulator load.
- R12: Priority per edge runs `clear`, then `load_addr`, then `int_entry`, then the program words together with `jmp_exec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of all field state |
| iot_strobe | input | 1 | Marks `instr` as an I/O transfer word this cycle |
| instr | input | 12 | Instruction word |
| ac_in | input | 12 | Accumulator value from the processor |
| jmp_exec | input | 1 | A jump or subroutine call executes this cycle |
| int_entry | input | 1 | Interrupt entry this cycle |
| load_addr | input | 1 | Operator load-address key |
| sw_ifield | input | 1 | Panel instruction-field switch |
| sw_dfield | input | 1 | Panel data-field switch |
| ac_out | output | 12 | Accumulator value with field bits merged in |
| ac_load | output | 1 | Accumulator load request |
| ac_enable | output | 1 | Accumulator input-path enable |
| int_inhibit | output | 1 | Holds off interrupts while a field change is pending |
| ifield | output | 1 | Current instruction field |
| dfield | output | 1 | Current data field |

## Verification
The bench builds the block with its default device selector of octal 62. With that selector, both the matching words and near misses on the device digits or the opcode can be tried. Because the word is 12 bits, the effect of each read word on every accumulator bit is checked over whole-word patterns such as all ones, all zeros and alternating bits. Nothing else in the design needs to be scaled to reach any corner. The two-step field change, the save and restore round trip and the priority collisions are all reached in a few dozen cycles.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

  localparam int WORD_W  = 12;
  localparam int FUNC_W  = 3;
  localparam int OPSEL_W = WORD_W - 2 * FUNC_W;
  localparam int SF_W    = 2;

  // bit positions counted from the MSB, as the instruction set numbers them
  localparam int FLD_BIT    = 8;
  localparam int CLR_A_BIT  = 6;
  localparam int CLR_B_BIT  = 7;
  localparam int SAVE_HI_BIT = 11;

  typedef struct packed {
    logic cdf;
    logic cif;
    logic rdf;
    logic rif;
    logic rib;
    logic rmf;
    logic fld;
  } mfc_op_t;

  function automatic int vidx(input int msb_bit);
    return WORD_W - 1 - msb_bit;
  endfunction

  function automatic logic [WORD_W-1:0] put_field(input logic [WORD_W-1:0] ac,
                                                 input logic f);
    logic [WORD_W-1:0] r;
    r = ac;
    r[vidx(CLR_A_BIT)] = 1'b0;
    r[vidx(CLR_B_BIT)] = 1'b0;
    r[vidx(FLD_BIT)]   = f;
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] put_saved(input logic [WORD_W-1:0] ac,
                                                 input logic [SF_W-1:0] sf);
    logic [WORD_W-1:0] r;
    r = ac;
    r[vidx(FLD_BIT)]     = sf[0];
    r[vidx(SAVE_HI_BIT)] = sf[1];
    return r;
  endfunction

endpackage

// File: rtl/mfc_decode.sv
module mfc_decode
  import mfc_pkg::*;
#(
  parameter logic [OPSEL_W-1:0] DEV_SEL = 6'o62
) (
  input  logic              iot_strobe,
  input  logic [WORD_W-1:0] instr,
  output mfc_op_t           op
);

  logic              dev_hit;
  logic [FUNC_W-1:0] low_d;
  logic [FUNC_W-1:0] mid_d;

  assign dev_hit = iot_strobe && (instr[WORD_W-1 -: OPSEL_W] == DEV_SEL);
  assign low_d   = instr[FUNC_W-1:0];
  assign mid_d   = instr[2*FUNC_W-1:FUNC_W];

  always_comb begin
    op     = '0;
    op.fld = instr[vidx(FLD_BIT)];
    if (dev_hit) begin
      case (low_d)
        3'd1: op.cdf = 1'b1;
        3'd2: op.cif = 1'b1;
        3'd4: begin
          case (mid_d)
            3'd1:    op.rdf = 1'b1;
            3'd2:    op.rif = 1'b1;
            3'd3:    op.rib = 1'b1;
            3'd4:    op.rmf = 1'b1;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mfc_regs.sv
module mfc_regs
  import mfc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            load_addr,
  input  logic            int_entry,
  input  logic            jmp_exec,
  input  logic            op_cdf,
  input  logic            op_cif,
  input  logic            op_rmf,
  input  logic            op_fld,
  input  logic            sw_ifield,
  input  logic            sw_dfield,
  output logic            if_q,
  output logic            ib_q,
  output logic            df_q,
  output logic [SF_W-1:0] sf_q,
  output logic            inh_q
);

  // named events for the checks below
  logic prog_en;
  logic take_int;
  logic take_la;
  assign take_la  = !clear && load_addr;
  assign take_int = !clear && !load_addr && int_entry;
  assign prog_en  = !clear && !load_addr && !int_entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      if_q <= 1'b0; ib_q <= 1'b0; df_q <= 1'b0; sf_q <= '0; inh_q <= 1'b0;
    end else if (clear) begin
      if_q <= 1'b0; ib_q <= 1'b0; df_q <= 1'b0; sf_q <= '0; inh_q <= 1'b0;
    end else if (load_addr) begin
      if_q  <= sw_ifield;
      ib_q  <= sw_ifield;
      df_q  <= sw_dfield;
      inh_q <= 1'b0;
    end else if (int_entry) begin
      sf_q <= {df_q, if_q};
      if_q <= 1'b0;
      ib_q <= 1'b0;
      df_q <= 1'b0;
    end else begin
      if (jmp_exec) begin
        if_q  <= ib_q;
        inh_q <= 1'b0;
      end
      if (op_cdf) df_q <= op_fld;
      if (op_cif) begin
        ib_q  <= op_fld;
        inh_q <= 1'b1;
      end
      if (op_rmf) begin
        ib_q <= sf_q[0];
        df_q <= sf_q[1];
      end
    end
  end

  // R2
  if_follows_ib_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && jmp_exec) |=> (if_q == $past(ib_q)));

  // R2
  if_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && !jmp_exec) |=> $stable(if_q));

  // R4
  int_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_int |=> (sf_q == $past({df_q, if_q})) && !if_q && !ib_q && !df_q);

  // R3
  inh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_q && prog_en && !jmp_exec) |=> inh_q);

  // R9
  la_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_la |=> (if_q == $past(sw_ifield)) && (ib_q == if_q) && !inh_q);

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !if_q && !ib_q && !df_q && (sf_q == '0) && !inh_q);

endmodule

// File: rtl/mfc_acmux.sv
module mfc_acmux
  import mfc_pkg::*;
(
  input  logic [WORD_W-1:0] ac_in,
  input  logic              op_rdf,
  input  logic              op_rif,
  input  logic              op_rib,
  input  logic              if_q,
  input  logic              df_q,
  input  logic [SF_W-1:0]   sf_q,
  output logic [WORD_W-1:0] ac_out,
  output logic              rd_any
);

  assign rd_any = op_rdf || op_rif || op_rib;

  always_comb begin
    if (op_rdf)      ac_out = put_field(ac_in, df_q);
    else if (op_rif) ac_out = put_field(ac_in, if_q);
    else if (op_rib) ac_out = put_saved(ac_in, sf_q);
    else             ac_out = ac_in;
  end

endmodule

// File: rtl/mem_field_ctl.sv
module mem_field_ctl
  import mfc_pkg::*;
#(
  parameter logic [OPSEL_W-1:0] DEV_SEL = 6'o62
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              iot_strobe,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] ac_in,
  input  logic              jmp_exec,
  input  logic              int_entry,
  input  logic              load_addr,
  input  logic              sw_ifield,
  input  logic              sw_dfield,
  output logic [WORD_W-1:0] ac_out,
  output logic              ac_load,
  output logic              ac_enable,
  output logic              int_inhibit,
  output logic              ifield,
  output logic              dfield
);

  mfc_op_t         op;
  logic            if_q, ib_q, df_q, inh_q, rd_any;
  logic [SF_W-1:0] sf_q;

  mfc_decode #(.DEV_SEL(DEV_SEL)) u_dec (
    .iot_strobe(iot_strobe), .instr(instr), .op(op)
  );

  mfc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load_addr(load_addr),
    .int_entry(int_entry), .jmp_exec(jmp_exec),
    .op_cdf(op.cdf), .op_cif(op.cif), .op_rmf(op.rmf), .op_fld(op.fld),
    .sw_ifield(sw_ifield), .sw_dfield(sw_dfield),
    .if_q(if_q), .ib_q(ib_q), .df_q(df_q), .sf_q(sf_q), .inh_q(inh_q)
  );

  mfc_acmux u_mux (
    .ac_in(ac_in), .op_rdf(op.rdf), .op_rif(op.rif), .op_rib(op.rib),
    .if_q(if_q), .df_q(df_q), .sf_q(sf_q), .ac_out(ac_out), .rd_any(rd_any)
  );

  assign ac_load     = rd_any;
  assign ac_enable   = rd_any;
  assign int_inhibit = inh_q || op.cif;
  assign ifield      = if_q;
  assign dfield      = df_q;

  // R11
  op_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op.cdf, op.cif, op.rdf, op.rif, op.rib, op.rmf}));

  // R8
  acld_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ac_load |-> iot_strobe);

  // R8
  acpass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ac_load |-> (ac_out == ac_in));

  // R3
  inh_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_exec && !op.cif && !int_entry && !clear) |=> !inh_q);

  // R1
  cdf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op.cdf && !clear && !load_addr && !int_entry) |=> (dfield == $past(op.fld)));

endmodule

// File: tb/mem_field_ctl_tb.sv
`timescale 1ns/1ps
module mem_field_ctl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0, iot_strobe = 1'b0, jmp_exec = 1'b0;
  logic        int_entry = 1'b0, load_addr = 1'b0, sw_ifield = 1'b0, sw_dfield = 1'b0;
  logic [11:0] instr = '0, ac_in = '0;
  logic [11:0] ac_out;
  logic        ac_load, ac_enable, int_inhibit, ifield, dfield;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model
  logic m_if = 0, m_ib = 0, m_df = 0, m_inh = 0;
  logic [1:0] m_sf = '0;

  always #2 clk = ~clk;  // 250 MHz

  mem_field_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .iot_strobe(iot_strobe),
    .instr(instr), .ac_in(ac_in), .jmp_exec(jmp_exec), .int_entry(int_entry),
    .load_addr(load_addr), .sw_ifield(sw_ifield), .sw_dfield(sw_dfield),
    .ac_out(ac_out), .ac_load(ac_load), .ac_enable(ac_enable),
    .int_inhibit(int_inhibit), .ifield(ifield), .dfield(dfield)
  );

  // ctrl {iot, jmp, intr, la} | sw {if, df} | 2'b0 | ac_in | instr
  localparam int NV = 22;
  localparam logic [31:0] VEC [NV] = '{
    {4'b1000, 2'b00, 2'b00, 12'o7777, 12'o6211},  // CDF 1
    {4'b1000, 2'b00, 2'b00, 12'o7777, 12'o6214},  // RDF
    {4'b1000, 2'b00, 2'b00, 12'o0000, 12'o6212},  // CIF 1
    {4'b1000, 2'b00, 2'b00, 12'o0000, 12'o6224},  // RIF, still 0
    {4'b0100, 2'b00, 2'b00, 12'o0000, 12'o0000},  // jump
    {4'b1000, 2'b00, 2'b00, 12'o1234, 12'o6224},  // RIF
    {4'b0010, 2'b00, 2'b00, 12'o0000, 12'o0000},  // interrupt
    {4'b1000, 2'b00, 2'b00, 12'o0000, 12'o6234},  // RIB
    {4'b1000, 2'b00, 2'b00, 12'o5555, 12'o6214},  // RDF
    {4'b1000, 2'b00, 2'b00, 12'o0000, 12'o6244},  // RMF
    {4'b1000, 2'b00, 2'b00, 12'o0000, 12'o6224},  // RIF before jump
    {4'b0100, 2'b00, 2'b00, 12'o0000, 12'o0000},  // jump
    {4'b1000, 2'b00, 2'b00, 12'o2525, 12'o6214},  // RDF
    {4'b1000, 2'b00, 2'b00, 12'o0000, 12'o6221},  // CDF N=2 -> 0
    {4'b1000, 2'b00, 2'b00, 12'o7777, 12'o6301},  // other device
    {4'b1010, 2'b00, 2'b00, 12'o0000, 12'o6211},  // CDF vs interrupt
    {4'b1001, 2'b11, 2'b00, 12'o0000, 12'o6201},  // load addr vs CDF
    {4'b1000, 2'b00, 2'b00, 12'o7777, 12'o6234},  // RIB
    {4'b1000, 2'b00, 2'b00, 12'o0000, 12'o6202},  // CIF 0
    {4'b0100, 2'b00, 2'b00, 12'o0000, 12'o0000},  // jump
    {4'b1000, 2'b00, 2'b00, 12'o1111, 12'o7211},  // not an IOT
    {4'b0100, 2'b00, 2'b00, 12'o0000, 12'o0000}   // jump, no change
  };

  function automatic logic bitn(input logic [11:0] w, input int k);
    return w[11 - k];
  endfunction

  function automatic logic [11:0] setn(input logic [11:0] w, input int k, input logic v);
    logic [11:0] r;
    r = w;
    r[11 - k] = v;
    return r;
  endfunction

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%o expected=%o at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic iot, input logic jmp, input logic intr,
                      input logic la, input logic clr, input logic swi,
                      input logic swd, input logic [11:0] acv, input logic [11:0] ins);
    logic is_cdf, is_cif, is_rdf, is_rif, is_rib, is_rmf;
    logic [11:0] exp_ac;
    logic n_if, n_ib, n_df, n_inh;
    logic [1:0] n_sf;
    string rtag;
    @(negedge clk);
    iot_strobe = iot; jmp_exec = jmp; int_entry = intr; load_addr = la;
    clear = clr; sw_ifield = swi; sw_dfield = swd; ac_in = acv; instr = ins;
    is_cdf = iot && ((ins & 12'o7707) == 12'o6201);
    is_cif = iot && ((ins & 12'o7707) == 12'o6202);
    is_rdf = iot && (ins == 12'o6214);
    is_rif = iot && (ins == 12'o6224);
    is_rib = iot && (ins == 12'o6234);
    is_rmf = iot && (ins == 12'o6244);
    exp_ac = acv;
    rtag = "R8";
    if (is_rdf || is_rif) begin
      exp_ac = setn(setn(setn(acv, 6, 1'b0), 7, 1'b0), 8, is_rdf ? m_df : m_if);
      rtag = "R6";
    end else if (is_rib) begin
      exp_ac = setn(setn(acv, 8, m_sf[0]), 11, m_sf[1]);
      rtag = "R7";
    end
    #1;
    chk(rtag, ac_out, exp_ac);
    chk("R8", {10'b0, ac_load, ac_enable},
        {10'b0, {2{is_rdf | is_rif | is_rib}}});
    chk("R3", {11'b0, int_inhibit}, {11'b0, m_inh | is_cif});
    // next state of the model from the pre-edge values
    n_if = m_if; n_ib = m_ib; n_df = m_df; n_inh = m_inh; n_sf = m_sf;
    if (clr) begin
      n_if = 0; n_ib = 0; n_df = 0; n_inh = 0; n_sf = 0;
    end else if (la) begin
      n_if = swi; n_ib = swi; n_df = swd; n_inh = 0;
    end else if (intr) begin
      n_sf = {m_df, m_if}; n_if = 0; n_ib = 0; n_df = 0;
    end else begin
      if (jmp) begin n_if = m_ib; n_inh = 0; end
      if (is_cdf) n_df = bitn(ins, 8);
      if (is_cif) begin n_ib = bitn(ins, 8); n_inh = 1; end
      if (is_rmf) begin n_ib = m_sf[0]; n_df = m_sf[1]; end
    end
    @(posedge clk);
    #1;
    m_if = n_if; m_ib = n_ib; m_df = n_df; m_inh = n_inh; m_sf = n_sf;
    if (clr) rtag = "R10";
    else if (la) rtag = "R9";
    else if (intr) rtag = (iot ? "R12" : "R4");
    else if (is_rmf) rtag = "R5";
    else if (is_cdf) rtag = "R1";
    else if (is_cif || jmp) rtag = "R2";
    else if (iot && !(is_rdf || is_rif || is_rib)) rtag = "R11";
    else rtag = "R2";
    chk(rtag, {11'b0, ifield}, {11'b0, m_if});
    chk(rtag, {11'b0, dfield}, {11'b0, m_df});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", {9'b0, ifield, dfield, int_inhibit}, 12'o0);
    chk("R10", {10'b0, ac_load, ac_enable}, 12'o0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][31], VEC[i][30], VEC[i][29], VEC[i][28], 1'b0,
           VEC[i][27], VEC[i][26], VEC[i][23:12], VEC[i][11:0]);
    end
    // R3: inhibit cleared by load_addr while a change is pending
    step(1, 0, 0, 0, 0, 0, 0, 12'o0, 12'o6212);
    step(0, 0, 0, 1, 0, 0, 1, 12'o0, 12'o0);
    step(0, 0, 0, 0, 0, 0, 0, 12'o0, 12'o0);
    // R10: clear with a pending change and saved state
    step(0, 0, 1, 0, 0, 0, 0, 12'o0, 12'o0);
    step(1, 0, 0, 0, 0, 0, 0, 12'o0, 12'o6212);
    step(1, 0, 0, 0, 0, 0, 0, 12'o0, 12'o6211);
    step(0, 0, 0, 0, 1, 0, 0, 12'o0, 12'o0);
    step(1, 0, 0, 0, 0, 0, 0, 12'o7777, 12'o6234);
    step(0, 1, 0, 0, 0, 0, 0, 12'o0, 12'o0);
    // R12: clear beats load_addr
    step(0, 0, 0, 1, 1, 1, 1, 12'o0, 12'o0);
    // R11: read word from another device has no accumulator effect
    step(1, 0, 0, 0, 0, 0, 0, 12'o3333, 12'o6114);
    // R5/R7 round trip from field 1
    step(0, 0, 0, 1, 0, 1, 0, 12'o0, 12'o0);
    step(0, 0, 1, 0, 0, 0, 0, 12'o0, 12'o0);
    step(1, 0, 0, 0, 0, 0, 0, 12'o0000, 12'o6234);
    step(1, 0, 0, 0, 0, 0, 0, 12'o0, 12'o6244);
    step(0, 1, 0, 0, 0, 0, 0, 12'o0, 12'o0);
    // R10 asynchronous reset mid-run
    @(negedge clk);
    iot_strobe = 0; jmp_exec = 0; load_addr = 0; int_entry = 0;
    rst_n = 1'b0;
    #1;
    chk("R10", {9'b0, ifield, dfield, int_inhibit}, 12'o0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule